// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock synthesizer and its output pins and decides, cycle by cycle, which generated clocks are allowed through. It gates one CPU clock and a bank of PCI clocks in response to three active-low requests: a CPU stop, a PCI stop and a power-down. It also drives enables for the reference output, the crystal oscillator and the VCOs. All timing decisions are taken in the domain of a free-running reference clock, which stands in for the always-running PCI clock. Every gated output parks low, and each output can only start or stop while its source clock is low. As a result, no output pulse is ever cut short or stretched.

The requests are asynchronous. They pass through a two-flop synchronizer on the reference clock. A four-state machine, `clk_stop_fsm`, then works out the run enables:
- ST_ACTIVE: clocks may run.
- ST_DRAIN: clocks are stopped and the oscillator is still on, for a fixed count.
- ST_OFF: oscillator and VCOs are off.
- ST_WAKE: oscillator and VCOs are back on, and the block waits a settling count.

The transitions are:
- ACTIVE to DRAIN when power-down is requested.
- DRAIN to OFF when the drain count expires.
- OFF to WAKE when power-down is released.
- WAKE to ACTIVE when the settling count expires.
- WAKE back to OFF if power-down returns during settling.

Reset starts the machine in ST_OFF.

Each gated output has its own gate cell, which re-times its run enable on the falling edge of its source. The CPU cell also synchronizes the enable into the CPU domain and holds back restart for a set number of CPU periods.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_n is low, cpu_clk_out, every pci_clk_out bit, ref_en, osc_en and vco_en are all 0.
- R2: With power-down inactive and the machine in ST_ACTIVE, the PCI outputs pulse at the k-th rising edge of ref_clk exactly when pci_stop_n was 1 at rising edge k-2. This is a fixed two-edge latency for both stopping and starting.
- R3: With cpu_stop_n low, cpu_clk_out produces no rising edge once 6 ref_clk rising edges have passed since the request. The PCI outputs keep running in that time.
- R4: After cpu_stop_n is released, at least 3 rising edges of cpu_clk are suppressed before the first pulse on cpu_clk_out.
- R5: Every high phase of a gated output equals its source's high phase. Every low phase is at least the source's low phase, so no pulse is truncated or stretched, and stopped outputs rest low.
- R6: After pwr_dn_n falls, the PCI outputs pulse at ref_clk rising edges 1 and 2 and no later. ref_en is 0 from edge 3. osc_en and vco_en are 0 from edge 3+DRAIN_CYC.
- R7: While power-down holds, toggling cpu_stop_n and pci_stop_n has no effect. The CPU and PCI outputs stay low, and ref_en and osc_en stay 0.
- R8: After pwr_dn_n rises, osc_en and vco_en are 1 from ref_clk edge 3. ref_en is 1 from edge 3+WAKE_CYC. The first PCI pulse comes at edge 4+WAKE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock (always-on PCI domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | N_PCI | PCI source clocks |
| cpu_stop_n | input | 1 | Active-low CPU stop request, asynchronous |
| pci_stop_n | input | 1 | Active-low PCI stop request, asynchronous |
| pwr_dn_n | input | 1 | Active-low power-down request, asynchronous |
| cpu_clk_out | output | 1 | Gated CPU clock, parks low |
| pci_clk_out | output | N_PCI | Gated PCI clocks, park low |
| ref_en | output | 1 | Reference output enable |
| osc_en | output | 1 | Crystal oscillator run enable |
| vco_en | output | 1 | VCO run enable |

## Verification
The bench builds the block with WAKE_CYC set to 16 in place of the default of about 100,000. This brings several complete power-down and wake cycles, each edge of which can be checked exactly, into a short run. DRAIN_CYC stays at 2 and CPU_WAIT stays at 3.

The CPU clock runs at a period of 14 ns against the 20 ns reference. This exercises the cross-domain restart hold-off and the stop bound with unrelated clocks. Six PCI lanes check that every lane of the bank follows the same two-edge rule.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_OFF    = 2'd2,
        ST_WAKE   = 2'd3
    } pm_state_t;
endpackage

// File: rtl/req_sync.sv
`timescale 1ns/1ps
module req_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Resets to zero so every request reads as "stopped" until sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/clk_stop_fsm.sv
`timescale 1ns/1ps
module clk_stop_fsm
    import clk_stop_pkg::*;
#(
    parameter int DRAIN_CYC = 2,
    parameter int WAKE_CYC  = 100000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pd_ok,
    input  logic cpu_ok,
    input  logic pci_ok,
    output logic cpu_run,
    output logic pci_run,
    output logic ref_en,
    output logic osc_en,
    output logic vco_en
);
    localparam int CNT_MAX = (DRAIN_CYC > WAKE_CYC) ? DRAIN_CYC : WAKE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    pm_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!pd_ok) begin
                    state_d = ST_DRAIN;
                    cnt_d   = '0;
                end
            end
            ST_DRAIN: begin
                if (cnt_q == CW'(DRAIN_CYC - 1)) state_d = ST_OFF;
                else                             cnt_d   = cnt_q + 1'b1;
            end
            ST_OFF: begin
                if (pd_ok) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
            end
            ST_WAKE: begin
                if (!pd_ok)                           state_d = ST_OFF;
                else if (cnt_q == CW'(WAKE_CYC - 1))  state_d = ST_ACTIVE;
                else                                  cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Power-down gates the run enables directly so entry costs no extra edge.
    always_comb begin
        cpu_run = (state_q == ST_ACTIVE) && pd_ok && cpu_ok;
        pci_run = (state_q == ST_ACTIVE) && pd_ok && pci_ok;
        ref_en  = (state_q == ST_ACTIVE);
        osc_en  = (state_q != ST_OFF);
        vco_en  = (state_q != ST_OFF);
    end

    p_drain_entry_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !pd_ok) |=> (state_q == ST_DRAIN && !ref_en && osc_en));

    p_osc_off_after_drain_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && cnt_q == CW'(DRAIN_CYC - 1)) |=> (!osc_en && !vco_en));

    p_wake_done_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_WAKE && pd_ok && cnt_q == CW'(WAKE_CYC - 1)) |=> ref_en);

    p_pd_holds_off_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_OFF && !pd_ok) |=> (!osc_en && !cpu_run && !pci_run));
endmodule

// File: rtl/clk_gate_neg.sv
`timescale 1ns/1ps
module clk_gate_neg #(
    parameter bit SYNC_IN  = 1'b0,
    parameter int WAIT_CYC = 0
) (
    input  logic rst_n,
    input  logic src,
    input  logic run,
    output logic gclk
);
    localparam int CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

    logic run_d;
    logic en_q;

    generate
        if (SYNC_IN) begin : g_sync
            logic s1_q, s2_q;
            always_ff @(negedge src or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= run;
                    s2_q <= s1_q;
                end
            end
            assign run_d = s2_q;
        end else begin : g_direct
            assign run_d = run;
        end

        if (WAIT_CYC > 0) begin : g_wait
            logic [CW-1:0] cnt_q;
            always_ff @(negedge src or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    en_q  <= 1'b0;
                end else begin
                    if (!run_d)                      cnt_q <= '0;
                    else if (cnt_q != CW'(WAIT_CYC)) cnt_q <= cnt_q + 1'b1;
                    en_q <= run_d && (cnt_q == CW'(WAIT_CYC));
                end
            end

            p_restart_wait_r4: assert property (@(negedge src) disable iff (!rst_n)
                $rose(en_q) |-> ($past(run_d, 1) && $past(run_d, 2)));
        end else begin : g_nowait
            always_ff @(negedge src or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= run_d;
            end
        end
    endgenerate

    // Enable only moves while src is low, so src & en_q never chops a pulse.
    assign gclk = src & en_q;

    p_stop_next_fall_r5: assert property (@(negedge src) disable iff (!rst_n)
        !run_d |=> !en_q);
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
    parameter int N_PCI     = 6,
    parameter int CPU_WAIT  = 3,
    parameter int DRAIN_CYC = 2,
    parameter int WAKE_CYC  = 100000
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             cpu_clk,
    input  logic [N_PCI-1:0] pci_clk,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic             cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic             ref_en,
    output logic             osc_en,
    output logic             vco_en
);
    logic [2:0] req_s;
    logic       cpu_run, pci_run;

    req_sync #(.WIDTH(3)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in ({pwr_dn_n, cpu_stop_n, pci_stop_n}),
        .sync_out (req_s)
    );

    clk_stop_fsm #(.DRAIN_CYC(DRAIN_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .pd_ok   (req_s[2]),
        .cpu_ok  (req_s[1]),
        .pci_ok  (req_s[0]),
        .cpu_run (cpu_run),
        .pci_run (pci_run),
        .ref_en  (ref_en),
        .osc_en  (osc_en),
        .vco_en  (vco_en)
    );

    clk_gate_neg #(.SYNC_IN(1'b1), .WAIT_CYC(CPU_WAIT)) u_cpu_gate (
        .rst_n (rst_n),
        .src   (cpu_clk),
        .run   (cpu_run),
        .gclk  (cpu_clk_out)
    );

    generate
        for (genvar i = 0; i < N_PCI; i++) begin : g_pci
            clk_gate_neg #(.SYNC_IN(1'b0), .WAIT_CYC(0)) u_pci_gate (
                .rst_n (rst_n),
                .src   (pci_clk[i]),
                .run   (pci_run),
                .gclk  (pci_clk_out[i])
            );
        end
    endgenerate
endmodule

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
    localparam int NP    = 6;
    localparam int WAKE  = 16;
    localparam int DRAIN = 2;

    logic ref_clk = 1'b0, cpu_clk = 1'b0, rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic cpu_clk_out, ref_en, osc_en, vco_en;
    logic [NP-1:0] pci_clk_out;

    int checks = 0, fails = 0;
    int src_cnt = 0, g_cnt = 0, g_src = 0;
    realtime p_rise = 0, p_fall = 0, c_rise = 0, c_fall = 0;

    always #10 ref_clk = ~ref_clk;
    always #7  cpu_clk = ~cpu_clk;

    clk_stop_ctrl #(.N_PCI(NP), .CPU_WAIT(3), .DRAIN_CYC(DRAIN), .WAKE_CYC(WAKE)) dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk({NP{ref_clk}}),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .ref_en(ref_en), .osc_en(osc_en), .vco_en(vco_en));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int ps(input realtime d);
        return int'(d * 1000.0);
    endfunction

    // R5 pulse-shape monitors: high phase exact, low phase never short
    always @(posedge pci_clk_out[0]) begin
        if (rst_n && p_fall > 0) check(ps($realtime - p_fall) >= 10000, "R5 pci low", ps($realtime - p_fall), 10000);
        p_rise = $realtime;
    end
    always @(negedge pci_clk_out[0]) begin
        if (rst_n && p_rise > 0) check(ps($realtime - p_rise) == 10000, "R5 pci high", ps($realtime - p_rise), 10000);
        p_fall = $realtime;
    end
    always @(posedge cpu_clk_out) begin
        if (rst_n && c_fall > 0) check(ps($realtime - c_fall) >= 7000, "R5 cpu low", ps($realtime - c_fall), 7000);
        c_rise = $realtime;
    end
    always @(negedge cpu_clk_out) begin
        if (rst_n && c_rise > 0) check(ps($realtime - c_rise) == 7000, "R5 cpu high", ps($realtime - c_rise), 7000);
        c_fall = $realtime;
    end

    // CPU edge bookkeeping: count source edges and which of them passed
    always @(posedge cpu_clk) begin
        src_cnt++;
        #1;
        if (cpu_clk_out) begin
            g_cnt++;
            g_src = src_cnt;
        end
    end

    task automatic at_negedge();
        @(negedge ref_clk);
        #2;
    endtask

    task automatic sample_edge();
        @(posedge ref_clk);
        #5;
    endtask

    initial begin
        #4_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int h1, h2, expv, g0, s0;
        void'($urandom(32'd20240611));

        // R1 reset state
        #35;
        check({cpu_clk_out, pci_clk_out, ref_en, osc_en, vco_en} == '0, "R1",
              int'({cpu_clk_out, pci_clk_out, ref_en, osc_en, vco_en}), 0);
        at_negedge();
        rst_n = 1'b1;
        repeat (WAKE + 10) @(posedge ref_clk);
        at_negedge();

        // R2 random stop traffic against a two-edge pipeline model
        h1 = pci_stop_n; h2 = pci_stop_n;
        for (int c = 0; c < 3000; c++) begin
            @(posedge ref_clk);
            expv = h2; h2 = h1; h1 = pci_stop_n;
            #5;
            check(pci_clk_out == {NP{expv[0]}}, "R2", int'(pci_clk_out), expv ? 63 : 0);
            @(negedge ref_clk);
            #2;
            if ($urandom_range(7) == 0) pci_stop_n = ~pci_stop_n;
            if ($urandom_range(15) == 0) cpu_stop_n = ~cpu_stop_n;
        end
        pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
        repeat (12) @(posedge ref_clk);

        // R3 CPU stop, PCI unaffected
        at_negedge();
        cpu_stop_n = 1'b0;
        repeat (6) @(posedge ref_clk);
        #1;
        g0 = g_cnt;
        for (int k = 0; k < 10; k++) begin
            sample_edge();
            check(pci_clk_out == '1, "R3 pci keeps running", int'(pci_clk_out), 63);
        end
        check(g_cnt == g0, "R3 cpu stopped", g_cnt - g0, 0);

        // R4 restart hold-off
        at_negedge();
        s0 = src_cnt; g0 = g_cnt;
        cpu_stop_n = 1'b1;
        for (int k = 0; k < 40 && g_cnt == g0; k++) @(posedge ref_clk);
        check(g_cnt != g0, "R4 cpu restarted", g_cnt - g0, 1);
        check(g_src - s0 - 1 >= 3, "R4 suppressed edges", g_src - s0 - 1, 3);
        repeat (5) @(posedge ref_clk);

        // R6 power-down entry
        at_negedge();
        pwr_dn_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            sample_edge();
            check(pci_clk_out == ((k <= 2) ? '1 : '0), "R6 pci", int'(pci_clk_out), (k <= 2) ? 63 : 0);
            check(ref_en == (k <= 2), "R6 ref_en", int'(ref_en), int'(k <= 2));
            check(osc_en == (k < 3 + DRAIN) && vco_en == osc_en, "R6 osc/vco", int'(osc_en), int'(k < 3 + DRAIN));
        end
        #1;
        g0 = g_cnt;

        // R7 stop inputs ignored during power-down
        for (int k = 0; k < 30; k++) begin
            at_negedge();
            cpu_stop_n = 1'($urandom_range(1));
            pci_stop_n = 1'($urandom_range(1));
            sample_edge();
            check(pci_clk_out == '0 && !ref_en && !osc_en, "R7",
                  int'({pci_clk_out, ref_en, osc_en}), 0);
        end
        check(g_cnt == g0, "R7 cpu held", g_cnt - g0, 0);
        at_negedge();
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (4) @(posedge ref_clk);

        // R8 wake sequence
        at_negedge();
        pwr_dn_n = 1'b1;
        for (int k = 1; k <= WAKE + 6; k++) begin
            sample_edge();
            check(osc_en == (k >= 3) && vco_en == (k >= 3), "R8 osc/vco", int'(osc_en), int'(k >= 3));
            check(ref_en == (k >= 3 + WAKE), "R8 ref_en", int'(ref_en), int'(k >= 3 + WAKE));
            check(pci_clk_out == ((k >= 4 + WAKE) ? '1 : '0), "R8 pci",
                  int'(pci_clk_out), (k >= 4 + WAKE) ? 63 : 0);
        end
        repeat (10) @(posedge ref_clk);
        check(g_cnt > g0, "R8 cpu resumed", g_cnt - g0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule